// File: doc/BRIEF.md
# Register-Topped Ring Stack

This block is the operand or return stack of a small stack processor. It holds 18-bit words. The newest word sits in a dedicated top register. Older words live in a 16-entry storage array. A one-hot pointer marks the array entry that holds the word just below the top. The pointer is kept in a circular shift register that rotates toward higher entries on a push and toward lower entries on a pop. Every operation completes in one clock cycle.

Both the top word and the word beneath it are always driven on outputs, so a two-operand ALU can read them together. A push writes the old top into the array and loads the input word into the top register. A pop reloads the top register from the entry under the pointer. A replace overwrites the top word and leaves the array and the pointer alone. No overflow or underflow is reported. Pushing a seventeenth word silently overwrites the oldest one, and popping past the bottom returns whatever the ring still holds.

Top module: `ring_stack`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `top_o` reads zero.
- R2: A push loads `din_i` into `top_o` on the cycle after the push is sampled.
- R3: After a push, `below_o` shows the value `top_o` had before the push.
- R4: Exactly one bit of the internal entry pointer is set at all times out of reset.
- R5: A pop moves the value shown on `below_o` into `top_o` on the next cycle, and `below_o` then shows the word stored one entry lower in the ring.
- R6: A replace loads `din_i` into `top_o` and leaves `below_o` and the pointer unchanged.
- R7: Controls are prioritised push over pop over replace. A pop or replace that arrives together with a higher-priority control has no effect.
- R8: With no control asserted, `top_o`, `below_o` and the pointer hold their values.
- R9: The ring holds 16 stored words below the top. Seventeen pushes overwrite the oldest stored word with no indication. Popping the same number of times then walks back through the ring modulo 16, so the seventeenth pop returns the word left by the sixteenth push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` upstream |
| push_i | input | 1 | Push `din_i` onto the stack |
| pop_i | input | 1 | Discard the top word |
| repl_i | input | 1 | Overwrite the top word with `din_i` |
| din_i | input | 18 | Word for push or replace |
| top_o | output | 18 | Current top word |
| below_o | output | 18 | Word directly under the top |

## Verification
The assertions assume that the controls and `din_i` are free of X and change only between rising edges. They also assume that any mix of the three controls is legal, because priority resolves it. Reads of array entries that were never written are not covered by the assertions. The bench keeps all of this true by driving inputs at the falling edge. It also tracks which ring entries hold defined data and compares `below_o` only against those entries.

// File: rtl/ring_stack_pkg.sv
package ring_stack_pkg;

  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_REPL = 2'd3
  } stk_op_e;

  // Fixed priority: push, then pop, then replace.
  function automatic stk_op_e stk_decode(input logic push, input logic pop,
                                         input logic repl);
    if (push)      return STK_PUSH;
    else if (pop)  return STK_POP;
    else if (repl) return STK_REPL;
    else           return STK_IDLE;
  endfunction

endpackage

// File: rtl/ring_stack_ptr.sv
module ring_stack_ptr #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_i,
  input  logic             down_i,
  output logic [DEPTH-1:0] ptr_o,
  output logic [DEPTH-1:0] ptr_up_o
);

  logic [DEPTH-1:0] ptr_q;
  logic [DEPTH-1:0] ptr_d;
  logic [DEPTH-1:0] rot_up;
  logic [DEPTH-1:0] rot_dn;
  logic             ptr_en;

  assign rot_up = {ptr_q[DEPTH-2:0], ptr_q[DEPTH-1]};
  assign rot_dn = {ptr_q[0], ptr_q[DEPTH-1:1]};
  assign ptr_en = up_i | down_i;

  always_comb begin
    ptr_d = ptr_q;
    if (up_i)        ptr_d = rot_up;
    else if (down_i) ptr_d = rot_dn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= {{(DEPTH-1){1'b0}}, 1'b1};
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o    = ptr_q;
  assign ptr_up_o = rot_up;

endmodule

// File: rtl/ring_stack_store.sv
module ring_stack_store #(
  parameter int W     = 18,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [DEPTH-1:0] wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [DEPTH-1:0] rd_sel_i,
  output logic [W-1:0]     rd_data_o
);

  logic [W-1:0] cell_q [DEPTH];
  logic [W-1:0] gated  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic cell_en;
    assign cell_en = wr_en_i & wr_sel_i[g];

    always_ff @(posedge clk) begin
      if (cell_en) cell_q[g] <= wr_data_i;
    end

    assign gated[g] = cell_q[g] & {W{rd_sel_i[g]}};
  end

  // One-hot read select: OR of the gated cells.
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++) rd_data_o = rd_data_o | gated[i];
  end

endmodule

// File: rtl/ring_stack.sv
module ring_stack #(
  parameter int W     = 18,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic         repl_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic [W-1:0] below_o
);
  import ring_stack_pkg::*;

  stk_op_e          op;
  logic [DEPTH-1:0] ptr_q;
  logic [DEPTH-1:0] ptr_up;
  logic [W-1:0]     top_q;
  logic [W-1:0]     top_d;
  logic             top_en;
  logic [W-1:0]     below;

  assign op = stk_decode(push_i, pop_i, repl_i);

  ring_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_i     (op == STK_PUSH),
    .down_i   (op == STK_POP),
    .ptr_o    (ptr_q),
    .ptr_up_o (ptr_up)
  );

  // Push spills the old top into the entry the pointer moves to.
  ring_stack_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .wr_en_i   (op == STK_PUSH),
    .wr_sel_i  (ptr_up),
    .wr_data_i (top_q),
    .rd_sel_i  (ptr_q),
    .rd_data_o (below)
  );

  always_comb begin
    top_en = 1'b1;
    top_d  = top_q;
    unique case (op)
      STK_PUSH: top_d = din_i;
      STK_REPL: top_d = din_i;
      STK_POP:  top_d = below;
      default:  top_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      top_q <= '0;
    else if (top_en) top_q <= top_d;
  end

  assign top_o   = top_q;
  assign below_o = below;

endmodule

// File: rtl/ring_stack_checker.sv
module ring_stack_checker #(
  parameter int W     = 18,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_i,
  input logic             pop_i,
  input logic             repl_i,
  input logic [W-1:0]     din_i,
  input logic [W-1:0]     top_o,
  input logic [W-1:0]     below_o,
  input logic [DEPTH-1:0] ptr_q
);

  // R1: top register is cleared by reset
  always_comb begin
    if (!rst_n) a_r1_reset_top: assert (top_o == '0);
  end

  a_r2_push_loads_top: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> top_o == $past(din_i));

  a_r3_push_spills_top: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> below_o == $past(top_o));

  a_r4_ptr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ptr_q) == 1);

  a_r5_pop_reloads_top: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> top_o == $past(below_o));

  a_r5_pop_rotates_back: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i) |=> $past(ptr_q) == {ptr_q[DEPTH-2:0], ptr_q[DEPTH-1]});

  a_r6_replace_keeps_below: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_i && !push_i && !pop_i) |=> $stable(ptr_q) && $stable(below_o)
      && top_o == $past(din_i));

  a_r7_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> $past(ptr_q) == {ptr_q[0], ptr_q[DEPTH-1:1]});

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i && !repl_i) |=> $stable(top_o) && $stable(ptr_q)
      && $stable(below_o));

endmodule

bind ring_stack ring_stack_checker #(.W(W), .DEPTH(DEPTH)) u_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .repl_i  (repl_i),
  .din_i   (din_i),
  .top_o   (top_o),
  .below_o (below_o),
  .ptr_q   (ptr_q)
);

// File: tb/test_ring_stack.sv
module test_ring_stack;
  localparam int W = 18;
  localparam int D = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         push, pop, repl;
  logic [W-1:0] din;
  logic [W-1:0] top, below;

  int n_chk = 0;
  int n_err = 0;

  // Reference model
  logic [W-1:0] m_top;
  logic [W-1:0] m_ring [D];
  logic         m_ok   [D];
  int           m_idx;

  always #2 clk = ~clk;

  ring_stack #(.W(W), .DEPTH(D)) i_ring_stack (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .repl_i(repl),
    .din_i(din), .top_o(top), .below_o(below)
  );

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_both(input string req);
    check(req, top, m_top);
    if (m_ok[m_idx]) check(req, below, m_ring[m_idx]);
  endtask

  // Drive at falling edge, apply through one rising edge, sample at next falling edge.
  task automatic step(input logic p, input logic q, input logic r,
                      input logic [W-1:0] d);
    push = p; pop = q; repl = r; din = d;
    @(negedge clk);
    if (p) begin
      m_idx = (m_idx + 1) % D;
      m_ring[m_idx] = m_top;
      m_ok[m_idx] = 1'b1;
      m_top = d;
    end else if (q) begin
      m_top = m_ring[m_idx];
      m_idx = (m_idx + D - 1) % D;
    end else if (r) begin
      m_top = d;
    end
    push = 0; pop = 0; repl = 0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; push = 0; pop = 0; repl = 0; din = '0;
    m_top = '0; m_idx = 0;
    for (int i = 0; i < D; i++) m_ok[i] = 1'b0;
    @(negedge clk);
    check("R1 during reset", top, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", top, '0);
  endtask

  task automatic t_push_pop;
    step(1, 0, 0, 18'h00A11); check_both("R2 R3 push 1");
    step(1, 0, 0, 18'h3FFFF); check_both("R2 R3 push 2");
    check("R3 below is previous top", below, 18'h00A11);
    step(1, 0, 0, 18'h12345); check_both("R2 push 3");
    step(0, 1, 0, '0);        check_both("R5 pop 1");
    check("R5 pop top", top, 18'h3FFFF);
    step(0, 1, 0, '0);        check_both("R5 pop 2");
    check("R5 below after pop", below, 18'h00000);
  endtask

  task automatic t_replace_idle;
    step(0, 0, 1, 18'h2BEEF); check_both("R6 replace");
    check("R6 below kept", below, 18'h00000);
    step(0, 0, 0, 18'h11111); check_both("R8 idle 1");
    step(0, 0, 0, 18'h22222); check_both("R8 idle 2");
    check("R8 top held", top, 18'h2BEEF);
  endtask

  task automatic t_priority;
    logic [W-1:0] prev;
    prev = top;
    step(1, 1, 1, 18'h0F0F0); check_both("R7 push over pop");
    check("R7 below is old top", below, prev);
    step(0, 1, 1, 18'h30303); check_both("R7 pop over replace");
    check("R7 top is popped value", top, prev);
  endtask

  task automatic t_wrap;
    for (int k = 1; k <= D + 1; k++) begin
      step(1, 0, 0, W'(18'h01000 + k));
      check_both("R9 fill");
    end
    for (int k = 1; k <= D + 1; k++) begin
      step(0, 1, 0, '0);
      check_both("R9 drain");
    end
    // 17th pop lands on the word left by push 16.
    check("R9 wrap returns overwritten entry", top, 18'h01010);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_push_pop();
        t_replace_idle();
        t_priority();
        t_wrap();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule